// File: doc/BRIEF.md
# Coherence Directory Home Slice with Forwarder Tracking

This block is one home slice of a directory spread across the tiles of a mesh. Caches that miss send it a query for a line. For every line it holds, the slice keeps the full set of tiles that share the line and at most one designated forwarder. On a read it either tells the forwarder to ship the data straight to the requestor or tells the memory interface to supply it. On a write it also names every other sharer to be invalidated. The slice commits the new sharer and forwarder state only when the requestor reports that the data has arrived.

Eviction notices from caches remove the sender from the sharer set. A dirty eviction turns into a write-back command to the memory interface. While a line waits for its data-complete report it is busy, and further queries to it are held at the input. A query for a line not in the table needs a free entry, and the input stalls when none is left. Commands leave through a single registered valid/ready channel, and completions arrive on a separate valid channel.

Top module: `dirslice_home`

## Requirements
- R1: A read query (req_kind 0) for a line with no forwarder produces a memory-read command (cmd_kind 2) to tile MEM_TILE, with cmd_req equal to the requestor and cmd_line equal to the line.
- R2: A read query for a line whose forwarder is another tile produces a forward-read command (cmd_kind 0) with cmd_dst equal to that forwarder.
- R3: Once a forwarded or fetched read completes, the requestor becomes the forwarder and the previous forwarder stays a sharer. The next read is then forwarded to the new forwarder.
- R4: When the forwarder evicts the line (req_kind 2), the forwarder is cleared and the next read is served from memory (cmd_kind 2).
- R5: A write query (req_kind 1) takes data from the forwarder or modified owner when that is another tile (cmd_kind 1 to it), and from memory otherwise (cmd_kind 2). cmd_inv holds bit t for every other sharer, excluding the requestor and the data source. After completion the writer is the sole, modified owner and serves the next read.
- R6: An eviction from the modified owner produces a write-back command (cmd_kind 3) to MEM_TILE. A clean eviction produces no command. An eviction from a tile that is not a sharer changes nothing.
- R7: A query to a line with an outstanding transaction is not accepted until the completion (done_valid with the requestor's tile and the line) arrives.
- R8: When every entry is in use, a query for an absent line is not accepted, while queries that hit proceed. An entry whose last sharer evicts is freed for reuse.
- R9: A forward command whose destination is the home tile HOME_TILE has cmd_local set, because it does not travel the mesh.
- R10: While cmd_valid is high and cmd_ready is low, the command stays unchanged and no new query is accepted.
- R11: After reset cmd_valid is low, the directory is empty, and req_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Query/eviction message valid |
| req_ready | output | 1 | Slice accepts the message this cycle |
| req_kind | input | 2 | 0 read, 1 write, 2 eviction |
| req_src | input | TILE_W | Requesting tile |
| req_line | input | LINE_W | Line address |
| cmd_valid | output | 1 | Command valid |
| cmd_ready | input | 1 | Command consumed |
| cmd_kind | output | 2 | 0 forward-read, 1 forward-write, 2 memory-read, 3 write-back |
| cmd_dst | output | TILE_W | Tile that receives the command |
| cmd_req | output | TILE_W | Tile the data goes to (or that wrote back) |
| cmd_line | output | LINE_W | Line address |
| cmd_inv | output | N_TILES | Tiles to invalidate on a write |
| cmd_local | output | 1 | Forward target is the home tile itself |
| done_valid | input | 1 | Data-complete report |
| done_src | input | TILE_W | Tile that received the data |
| done_line | input | LINE_W | Line that completed |

## Verification
On every cycle the assertions check that a forward never targets its own requestor, that memory commands always go to the memory tile, that the requestor is never in its own invalidate set, that a stalled command holds still, and that each entry keeps its forwarder inside its sharer set, with a modified line held by exactly one tile. Forwarder migration, clearing of the forwarder on eviction, the choice of data source for a write, busy-line holding and full-table stalls depend on the order of messages. Only the bench's scenarios can show these, because each is visible only in the command a later query produces.

// File: rtl/dirslice_pkg.sv
package dirslice_pkg;

  typedef enum logic [1:0] {
    RQ_READ  = 2'd0,
    RQ_WRITE = 2'd1,
    RQ_EVICT = 2'd2,
    RQ_NONE  = 2'd3
  } req_kind_e;

  typedef enum logic [1:0] {
    CM_FWD_RD = 2'd0,
    CM_FWD_WR = 2'd1,
    CM_MEM_RD = 2'd2,
    CM_MEM_WB = 2'd3
  } cmd_kind_e;

  function automatic logic is_forward(input logic [1:0] k);
    return (k == CM_FWD_RD) || (k == CM_FWD_WR);
  endfunction

  function automatic logic is_query(input logic [1:0] k);
    return (k == RQ_READ) || (k == RQ_WRITE);
  endfunction

endpackage

// File: rtl/dirslice_cam.sv
module dirslice_cam #(
  parameter int unsigned N_ENTRIES = 4,
  parameter int unsigned LINE_W    = 16,
  localparam int unsigned IDX_W    = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [N_ENTRIES-1:0]          ent_vld,
  input  logic [N_ENTRIES*LINE_W-1:0]   ent_tags,
  input  logic [LINE_W-1:0]             key,
  output logic                          hit,
  output logic [IDX_W-1:0]              hit_idx
);

  logic [N_ENTRIES-1:0] match;

  for (genvar g = 0; g < N_ENTRIES; g++) begin : g_cmp
    assign match[g] = ent_vld[g] && (ent_tags[g*LINE_W +: LINE_W] == key);
  end

  function automatic logic [IDX_W-1:0] lowest(input logic [N_ENTRIES-1:0] v);
    logic [IDX_W-1:0] r;
    r = '0;
    for (int i = N_ENTRIES - 1; i >= 0; i--) begin
      if (v[i]) r = IDX_W'(i);
    end
    return r;
  endfunction

  assign hit     = |match;
  assign hit_idx = lowest(match);

  // R8: a line lives in at most one entry
  a_r8_single_hit: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(match));

endmodule

// File: rtl/dirslice_decide.sv
module dirslice_decide
  import dirslice_pkg::*;
#(
  parameter int unsigned N_TILES  = 8,
  parameter int unsigned MEM_TILE = 7,
  localparam int unsigned TILE_W  = (N_TILES > 1) ? $clog2(N_TILES) : 1
) (
  input  logic [1:0]         kind,
  input  logic [TILE_W-1:0]  src,
  input  logic               hit,
  input  logic [N_TILES-1:0] sharers,
  input  logic               fwd_vld,
  input  logic [TILE_W-1:0]  fwd_id,
  input  logic               modified,
  output logic               emit,
  output logic [1:0]         ckind,
  output logic [TILE_W-1:0]  cdst,
  output logic [N_TILES-1:0] cinv,
  output logic               start_txn,
  output logic               evict_upd,
  output logic [N_TILES-1:0] new_sharers,
  output logic               new_fwd_vld,
  output logic               new_mod,
  output logic               drop_entry
);

  logic [N_TILES-1:0] src_bit;
  logic [N_TILES-1:0] fwd_bit;
  logic               fwd_other;
  logic [N_TILES-1:0] cur_sh;

  assign src_bit   = N_TILES'(1) << src;
  assign fwd_bit   = N_TILES'(1) << fwd_id;
  assign fwd_other = hit && fwd_vld && (fwd_id != src);
  assign cur_sh    = hit ? sharers : '0;

  always_comb begin
    emit        = 1'b0;
    ckind       = CM_MEM_RD;
    cdst        = TILE_W'(MEM_TILE);
    cinv        = '0;
    start_txn   = 1'b0;
    evict_upd   = 1'b0;
    new_sharers = sharers;
    new_fwd_vld = fwd_vld;
    new_mod     = modified;
    drop_entry  = 1'b0;
    case (req_kind_e'(kind))
      RQ_READ: begin
        start_txn = 1'b1;
        emit      = 1'b1;
        if (fwd_other) begin
          ckind = CM_FWD_RD;
          cdst  = fwd_id;
        end
      end
      RQ_WRITE: begin
        start_txn = 1'b1;
        emit      = 1'b1;
        if (fwd_other) begin
          ckind = CM_FWD_WR;
          cdst  = fwd_id;
        end
        cinv = cur_sh & ~src_bit & ~(fwd_other ? fwd_bit : '0);
      end
      RQ_EVICT: begin
        if (hit && sharers[src]) begin
          evict_upd   = 1'b1;
          new_sharers = sharers & ~src_bit;
          if (fwd_vld && fwd_id == src) new_fwd_vld = 1'b0;
          if (modified) begin
            emit    = 1'b1;
            ckind   = CM_MEM_WB;
            new_mod = 1'b0;
          end
          drop_entry = (new_sharers == '0);
        end
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/dirslice_home.sv
module dirslice_home
  import dirslice_pkg::*;
#(
  parameter int unsigned N_TILES   = 8,
  parameter int unsigned N_ENTRIES = 4,
  parameter int unsigned LINE_W    = 16,
  parameter int unsigned HOME_TILE = 2,
  parameter int unsigned MEM_TILE  = 7,
  localparam int unsigned TILE_W   = (N_TILES > 1) ? $clog2(N_TILES) : 1,
  localparam int unsigned IDX_W    = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [1:0]         req_kind,
  input  logic [TILE_W-1:0]  req_src,
  input  logic [LINE_W-1:0]  req_line,
  output logic               cmd_valid,
  input  logic               cmd_ready,
  output logic [1:0]         cmd_kind,
  output logic [TILE_W-1:0]  cmd_dst,
  output logic [TILE_W-1:0]  cmd_req,
  output logic [LINE_W-1:0]  cmd_line,
  output logic [N_TILES-1:0] cmd_inv,
  output logic               cmd_local,
  input  logic               done_valid,
  input  logic [TILE_W-1:0]  done_src,
  input  logic [LINE_W-1:0]  done_line
);

  // directory storage
  logic [N_ENTRIES-1:0] e_vld, e_fv, e_mod, e_busy, e_pwr;
  logic [LINE_W-1:0]    e_line [N_ENTRIES];
  logic [N_TILES-1:0]   e_sh   [N_ENTRIES];
  logic [TILE_W-1:0]    e_fid  [N_ENTRIES];
  logic [TILE_W-1:0]    e_preq [N_ENTRIES];
  logic [N_ENTRIES*LINE_W-1:0] tags_flat;

  for (genvar g = 0; g < N_ENTRIES; g++) begin : g_flat
    assign tags_flat[g*LINE_W +: LINE_W] = e_line[g];
  end

  // lookups: one for the request port, one for completions
  logic             hit_r, hit_d;
  logic [IDX_W-1:0] idx_r, idx_d;

  dirslice_cam #(.N_ENTRIES(N_ENTRIES), .LINE_W(LINE_W)) u_cam_req (
    .clk(clk), .rst_n(rst_n), .ent_vld(e_vld), .ent_tags(tags_flat),
    .key(req_line), .hit(hit_r), .hit_idx(idx_r));

  dirslice_cam #(.N_ENTRIES(N_ENTRIES), .LINE_W(LINE_W)) u_cam_done (
    .clk(clk), .rst_n(rst_n), .ent_vld(e_vld), .ent_tags(tags_flat),
    .key(done_line), .hit(hit_d), .hit_idx(idx_d));

  function automatic logic [IDX_W-1:0] first_free(input logic [N_ENTRIES-1:0] v);
    logic [IDX_W-1:0] r;
    r = '0;
    for (int i = N_ENTRIES - 1; i >= 0; i--) begin
      if (!v[i]) r = IDX_W'(i);
    end
    return r;
  endfunction

  logic             free_any;
  logic [IDX_W-1:0] free_idx, sel_idx;
  assign free_any = ~&e_vld;
  assign free_idx = first_free(e_vld);
  assign sel_idx  = hit_r ? idx_r : free_idx;

  // policy decision for the presented message
  logic               d_emit, d_start, d_evupd, d_nfv, d_nmod, d_drop;
  logic [1:0]         d_kind;
  logic [TILE_W-1:0]  d_dst;
  logic [N_TILES-1:0] d_inv, d_nsh;

  dirslice_decide #(.N_TILES(N_TILES), .MEM_TILE(MEM_TILE)) u_decide (
    .kind(req_kind), .src(req_src), .hit(hit_r),
    .sharers(e_sh[idx_r]), .fwd_vld(e_fv[idx_r]), .fwd_id(e_fid[idx_r]),
    .modified(e_mod[idx_r]),
    .emit(d_emit), .ckind(d_kind), .cdst(d_dst), .cinv(d_inv),
    .start_txn(d_start), .evict_upd(d_evupd), .new_sharers(d_nsh),
    .new_fwd_vld(d_nfv), .new_mod(d_nmod), .drop_entry(d_drop));

  // named events
  logic line_busy, need_alloc, ev_req_fire, ev_ack, cmd_vq;
  assign line_busy   = hit_r && e_busy[idx_r];
  assign need_alloc  = !hit_r && is_query(req_kind);
  assign req_ready   = !cmd_vq && !line_busy && !(need_alloc && !free_any);
  assign ev_req_fire = req_valid && req_ready;
  assign ev_ack      = done_valid && hit_d && e_busy[idx_d] && (e_preq[idx_d] == done_src);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      e_vld  <= '0;
      e_busy <= '0;
      cmd_vq <= 1'b0;
    end else begin
      if (ev_ack) begin
        e_busy[idx_d] <= 1'b0;
        e_fv[idx_d]   <= 1'b1;
        e_fid[idx_d]  <= done_src;
        e_mod[idx_d]  <= e_pwr[idx_d];
        e_sh[idx_d]   <= e_pwr[idx_d] ? (N_TILES'(1) << done_src)
                                      : (e_sh[idx_d] | (N_TILES'(1) << done_src));
      end
      if (ev_req_fire && d_start) begin
        e_vld[sel_idx]  <= 1'b1;
        e_line[sel_idx] <= req_line;
        e_busy[sel_idx] <= 1'b1;
        e_preq[sel_idx] <= req_src;
        e_pwr[sel_idx]  <= (req_kind == RQ_WRITE);
        if (!hit_r) begin
          e_sh[sel_idx]  <= '0;
          e_fv[sel_idx]  <= 1'b0;
          e_mod[sel_idx] <= 1'b0;
        end
      end else if (ev_req_fire && d_evupd) begin
        e_sh[idx_r]  <= d_nsh;
        e_fv[idx_r]  <= d_nfv;
        e_mod[idx_r] <= d_nmod;
        if (d_drop) e_vld[idx_r] <= 1'b0;
      end
      if (ev_req_fire && d_emit) begin
        cmd_vq    <= 1'b1;
        cmd_kind  <= d_kind;
        cmd_dst   <= d_dst;
        cmd_req   <= req_src;
        cmd_line  <= req_line;
        cmd_inv   <= d_inv;
        cmd_local <= is_forward(d_kind) && (d_dst == TILE_W'(HOME_TILE));
      end else if (cmd_ready) begin
        cmd_vq <= 1'b0;
      end
    end
  end

  assign cmd_valid = cmd_vq;

  // R2: a forward never goes back to its own requestor
  a_r2_fwd_not_self: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && is_forward(cmd_kind) |-> cmd_dst != cmd_req);

  // R1: memory commands always target the memory tile
  a_r1_mem_dst: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !is_forward(cmd_kind) |-> cmd_dst == TILE_W'(MEM_TILE));

  // R5: the writer is never told to invalidate itself
  a_r5_inv_excl: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> !cmd_inv[cmd_req]);

  // R10: stalled command holds
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_kind) &&
      $stable(cmd_dst) && $stable(cmd_line) && $stable(cmd_inv));

  for (genvar g = 0; g < N_ENTRIES; g++) begin : g_chk
    // R3: the forwarder is always one of the sharers
    a_r3_fwd_in_sharers: assert property (@(posedge clk) disable iff (!rst_n)
      e_vld[g] && e_fv[g] |-> e_sh[g][e_fid[g]]);
    // R5: a modified line has exactly one holder
    a_r5_mod_sole: assert property (@(posedge clk) disable iff (!rst_n)
      e_vld[g] && e_mod[g] |-> $countones(e_sh[g]) == 1);
  end

endmodule

// File: tb/dirslice_home_tb_top.sv
`timescale 1ns/1ps
module dirslice_home_tb_top;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       req_valid, req_ready;
  logic [1:0] req_kind;
  logic [2:0] req_src;
  logic [15:0] req_line;
  logic       cmd_valid, cmd_ready;
  logic [1:0] cmd_kind;
  logic [2:0] cmd_dst, cmd_req;
  logic [15:0] cmd_line;
  logic [7:0] cmd_inv;
  logic       cmd_local;
  logic       done_valid;
  logic [2:0] done_src;
  logic [15:0] done_line;

  always #2 clk = ~clk;

  dirslice_home dut_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_kind(req_kind),
    .req_src(req_src), .req_line(req_line),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_kind(cmd_kind),
    .cmd_dst(cmd_dst), .cmd_req(cmd_req), .cmd_line(cmd_line),
    .cmd_inv(cmd_inv), .cmd_local(cmd_local),
    .done_valid(done_valid), .done_src(done_src), .done_line(done_line));

  int n_chk = 0;
  int n_fail = 0;

  localparam logic [15:0] LA = 16'h0A10, LB = 16'h0B20, LC = 16'h0C30,
                          LD = 16'h0D40, LE = 16'h0E50, LF = 16'h0F60;

  typedef struct packed {
    logic [1:0]  kind;
    logic [2:0]  src;
    logic [15:0] line;
    logic        ev;
    logic [1:0]  ek;
    logic [2:0]  ed;
    logic [7:0]  ei;
    logic        el;
    logic        ack;
  } vec_t;

  // home tile 2, memory tile 7
  localparam vec_t VECS [10] = '{
    '{2'd0, 3'd1, LA, 1'b1, 2'd2, 3'd7, 8'h00, 1'b0, 1'b1},  // R1 cold read from memory
    '{2'd0, 3'd3, LA, 1'b1, 2'd0, 3'd1, 8'h00, 1'b0, 1'b1},  // R2 forward to tile 1
    '{2'd0, 3'd4, LA, 1'b1, 2'd0, 3'd3, 8'h00, 1'b0, 1'b1},  // R3 forwarder moved to 3
    '{2'd2, 3'd4, LA, 1'b0, 2'd0, 3'd0, 8'h00, 1'b0, 1'b0},  // R4 forwarder evicts, clean
    '{2'd0, 3'd5, LA, 1'b1, 2'd2, 3'd7, 8'h00, 1'b0, 1'b1},  // R4 next read from memory
    '{2'd1, 3'd1, LA, 1'b1, 2'd1, 3'd5, 8'h08, 1'b0, 1'b1},  // R5 write, data from 5, inval 3
    '{2'd0, 3'd2, LA, 1'b1, 2'd0, 3'd1, 8'h00, 1'b0, 1'b1},  // R5 owner 1 serves
    '{2'd0, 3'd6, LA, 1'b1, 2'd0, 3'd2, 8'h00, 1'b1, 1'b1},  // R9 forward to home tile
    '{2'd1, 3'd0, LB, 1'b1, 2'd2, 3'd7, 8'h00, 1'b0, 1'b1},  // R5 write miss from memory
    '{2'd2, 3'd0, LB, 1'b1, 2'd3, 3'd7, 8'h00, 1'b0, 1'b0}   // R6 dirty eviction write-back
  };
  localparam string VTAG [10] = '{"R1", "R2", "R3", "R4", "R4", "R5", "R5", "R9", "R5", "R6"};

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // all tasks start and end just after a falling edge
  task automatic issue(input logic [1:0] k, input logic [2:0] s, input logic [15:0] l);
    req_valid = 1'b1; req_kind = k; req_src = s; req_line = l;
    #1;
    while (!req_ready) begin
      @(negedge clk); #1;
    end
    @(negedge clk);
    req_valid = 1'b0;
    #1;
  endtask

  task automatic ack(input logic [2:0] s, input logic [15:0] l);
    done_valid = 1'b1; done_src = s; done_line = l;
    @(negedge clk);
    done_valid = 1'b0;
  endtask

  task automatic expect_cmd(input string tag, input logic [1:0] k, input logic [2:0] d,
                            input logic [2:0] r, input logic [15:0] l,
                            input logic [7:0] inv, input logic loc);
    chk({tag, " valid"}, 32'(cmd_valid), 32'd1);
    chk({tag, " kind"},  32'(cmd_kind),  32'(k));
    chk({tag, " dst"},   32'(cmd_dst),   32'(d));
    chk({tag, " req"},   32'(cmd_req),   32'(r));
    chk({tag, " line"},  32'(cmd_line),  32'(l));
    chk({tag, " inv"},   32'(cmd_inv),   32'(inv));
    chk({tag, " local"}, 32'(cmd_local), 32'(loc));
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog R11 actual=timeout expected=completion");
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_kind = '0; req_src = '0; req_line = '0;
    cmd_ready = 1'b1; done_valid = 1'b0; done_src = '0; done_line = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk("R11 cmd_valid after reset", 32'(cmd_valid), 32'd0);
    chk("R11 req_ready after reset", 32'(req_ready), 32'd1);

    // table walk
    for (int i = 0; i < 10; i++) begin
      issue(VECS[i].kind, VECS[i].src, VECS[i].line);
      if (VECS[i].ev)
        expect_cmd(VTAG[i], VECS[i].ek, VECS[i].ed, VECS[i].src, VECS[i].line,
                   VECS[i].ei, VECS[i].el);
      else
        chk({VTAG[i], " no command"}, 32'(cmd_valid), 32'd0);
      if (VECS[i].ack) ack(VECS[i].src, VECS[i].line);
    end

    // R7: busy line holds a second query until completion
    issue(2'd0, 3'd1, LC);
    expect_cmd("R7 first read", 2'd2, 3'd7, 3'd1, LC, 8'h00, 1'b0);
    req_valid = 1'b1; req_kind = 2'd0; req_src = 3'd3; req_line = LC;
    repeat (3) @(negedge clk);
    #1;
    chk("R7 held while busy", 32'(req_ready), 32'd0);
    done_valid = 1'b1; done_src = 3'd1; done_line = LC;
    @(negedge clk);
    done_valid = 1'b0;
    #1;
    chk("R7 released after completion", 32'(req_ready), 32'd1);
    @(negedge clk);
    req_valid = 1'b0;
    #1;
    expect_cmd("R7 held read", 2'd0, 3'd1, 3'd3, LC, 8'h00, 1'b0);
    ack(3'd3, LC);

    // R8: fill the table (A, C, D, E)
    issue(2'd0, 3'd0, LD); ack(3'd0, LD);
    issue(2'd0, 3'd0, LE); ack(3'd0, LE);
    req_valid = 1'b1; req_kind = 2'd0; req_src = 3'd0; req_line = LF;
    repeat (2) @(negedge clk);
    #1;
    chk("R8 full table stalls new line", 32'(req_ready), 32'd0);
    req_valid = 1'b0;
    @(negedge clk);
    issue(2'd0, 3'd1, LE);
    expect_cmd("R8 hit proceeds when full", 2'd0, 3'd0, 3'd1, LE, 8'h00, 1'b0);
    ack(3'd1, LE);
    issue(2'd2, 3'd0, LD);
    chk("R8 last sharer evicts, no command", 32'(cmd_valid), 32'd0);
    issue(2'd0, 3'd0, LF);
    expect_cmd("R8 freed entry reused", 2'd2, 3'd7, 3'd0, LF, 8'h00, 1'b0);
    ack(3'd0, LF);

    // R10: back-pressure on the command channel
    cmd_ready = 1'b0;
    issue(2'd0, 3'd4, LF);
    expect_cmd("R10 stalled command", 2'd0, 3'd0, 3'd4, LF, 8'h00, 1'b0);
    req_valid = 1'b1; req_kind = 2'd2; req_src = 3'd7; req_line = LA;
    repeat (3) @(negedge clk);
    #1;
    chk("R10 still valid", 32'(cmd_valid), 32'd1);
    chk("R10 dst stable", 32'(cmd_dst), 32'd0);
    chk("R10 no accept while stalled", 32'(req_ready), 32'd0);
    cmd_ready = 1'b1;
    while (!req_ready) begin
      @(negedge clk); #1;
    end
    @(negedge clk);
    req_valid = 1'b0;
    #1;
    chk("R6 non-sharer eviction, no command", 32'(cmd_valid), 32'd0);
    ack(3'd4, LF);

    // R6: state of A unchanged by the non-sharer eviction (forwarder still 6)
    issue(2'd0, 3'd3, LA);
    expect_cmd("R6 forwarder unchanged", 2'd0, 3'd6, 3'd3, LA, 8'h00, 1'b0);
    ack(3'd3, LA);

    repeat (2) @(negedge clk);
    summary();
    $finish;
  end

endmodule